// File: doc/BRIEF.md
# Boot-Window Two-Cycle Command Decoder

This block sits behind the boot-buffer address window of a flash controller and turns host writes into actions. A write that lands inside the window is a command. One code asks for a warm reset. Another fills the first three boot-buffer words with identification data: a manufacturer byte, a device byte and the low byte of the protection status. A third code arms a second cycle. If the next window write carries zero, a page load starts at the current block and page address. The page register then moves to the next page.

The block owns the page register. The host can also load that register directly through a dedicated port. The block register is an input. If its top bit is set, a density mask is merged into the block number. The sector number sent out with the load request is formed from the block number and the low page byte. A page load always moves four 512-byte sectors into data buffer 0. The block holds the request until the array side signals completion on a single done input. The transfer itself happens outside this block.

Top module: `boot_cmd_decoder`

## Requirements
- R1: Only writes with `wr_addr_i` in 0x0000–0x01FF or 0x8000–0x800F are decoded. Any other write changes no output and leaves a pending second cycle armed.
- R2: A decoded write of 0x00F0 while not armed raises `rst_req_o` for exactly the next cycle and clears the page register to zero.
- R3: A decoded write of 0x0090 while not armed gives three consecutive `buf_we_o` cycles, starting the next cycle, with `buf_idx_o` 0, 1, 2. The data are the zero-extended manufacturer byte, device byte and `wp_status_i[7:0]`, all captured in the command cycle.
- R4: A decoded write of 0x00E0 arms a second cycle. The next decoded write always disarms it. Only the value 0x0000 starts a page load. Any other value gives no reset, no ID fill and no unknown-command pulse.
- R5: `load_sector_o` = {blk, page[7:0]} (20 bits). `blk` is `blk_reg_i[11:0]`, ORed with the DENSITY_MASK parameter (default 0x400) when `blk_reg_i[15]` is 1.
- R6: When a load starts, the page register becomes ((page[7:0] + 4) mod 256), with bits 15:8 cleared. `page_o` shows the new value the next cycle.
- R7: `load_req_o` rises the cycle after the zero second write. It stays high with a stable `load_sector_o` until `load_done_i` is sampled high, and is low the cycle after that.
- R8: A zero second write while `load_req_o` is high is dropped. No new request is made, the page register is unchanged, and the armed flag is still cleared.
- R9: Any other value written while not armed raises `unk_cmd_o` for exactly one cycle and has no other effect.
- R10: `pg_wr_i` loads `pg_data_i` into the page register. It takes priority over the load increment and the reset clear in the same cycle.
- R11: After reset, all request and strobe outputs are low, `page_o` is zero and no second cycle is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 16 | Host write word offset |
| wr_data_i | input | 16 | Host write value |
| pg_wr_i | input | 1 | Direct page register load |
| pg_data_i | input | 16 | Value for page register load |
| blk_reg_i | input | 16 | Block address register |
| mfr_id_i | input | 8 | Manufacturer ID byte |
| dev_id_i | input | 8 | Device ID byte |
| wp_status_i | input | 16 | Protection status word |
| load_done_i | input | 1 | Page transfer complete |
| rst_req_o | output | 1 | Warm reset request pulse |
| unk_cmd_o | output | 1 | Unknown command pulse |
| buf_we_o | output | 1 | Boot buffer word write strobe |
| buf_idx_o | output | 2 | Boot buffer word index |
| buf_data_o | output | 16 | Boot buffer write data |
| load_req_o | output | 1 | Page load request |
| load_sector_o | output | 20 | First sector of the page load |
| page_o | output | 16 | Current page register |

## Verification
The hardest cases to reach from the ports involve timing at one clock edge. One is a second zero write that arrives while an earlier load is still pending. The bench holds `load_done_i` low, arms again and writes zero, then checks that the request, the sector and the page stay as they were. The other is a direct page write on the same edge that a load starts. The bench drives both strobes in one cycle. It then checks that the sector was built from the old page and that the page holds the written value rather than the incremented one. The armed state is not visible at a port. It is shown through what follows: a zero write after an out-of-window write still loads, and a reset code used as the second cycle produces no pulse.

// File: rtl/boot_cmd_pkg.sv
package boot_cmd_pkg;
  localparam int unsigned DATA_W = 16;
  localparam logic [DATA_W-1:0] CODE_RESET = 16'h00F0;
  localparam logic [DATA_W-1:0] CODE_ARM   = 16'h00E0;
  localparam logic [DATA_W-1:0] CODE_ID    = 16'h0090;

  typedef struct packed {
    logic rst;
    logic id;
    logic load;
    logic unk;
  } cmd_strobe_t;
endpackage

// File: rtl/boot_cmd_window.sv
module boot_cmd_window #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] LO_LAST  = 16'h01FF,
  parameter logic [ADDR_W-1:0] HI_FIRST = 16'h8000,
  parameter logic [ADDR_W-1:0] HI_LAST  = 16'h800F
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  logic in_lo, in_hi;
  assign in_lo = (addr_i <= LO_LAST);
  assign in_hi = (addr_i >= HI_FIRST) && (addr_i <= HI_LAST);
  assign hit_o = wr_en_i && (in_lo || in_hi);
endmodule

// File: rtl/boot_cmd_seq.sv
module boot_cmd_seq
  import boot_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] data_i,
  output cmd_strobe_t       cmd_o,
  output logic              rst_req_o,
  output logic              unk_cmd_o
);
  logic armed_q, armed_d;
  cmd_strobe_t cmd_c;

  always_comb begin
    cmd_c   = '0;
    armed_d = armed_q;
    if (hit_i) begin
      armed_d = 1'b0;
      if (armed_q) begin
        cmd_c.load = (data_i == '0);
      end else begin
        unique case (data_i)
          CODE_RESET: cmd_c.rst = 1'b1;
          CODE_ID:    cmd_c.id  = 1'b1;
          CODE_ARM:   armed_d   = 1'b1;
          default:    cmd_c.unk = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b0;
      rst_req_o <= 1'b0;
      unk_cmd_o <= 1'b0;
    end else begin
      armed_q   <= armed_d;
      rst_req_o <= cmd_c.rst;
      unk_cmd_o <= cmd_c.unk;
    end
  end

  assign cmd_o = cmd_c;

  AST_ARM_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && hit_i) |=> !armed_q); // R4
  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rst_req_o, unk_cmd_o})); // R9
  AST_ARMED_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && hit_i) |=> (!rst_req_o && !unk_cmd_o)); // R4
endmodule

// File: rtl/boot_cmd_idfill.sv
module boot_cmd_idfill #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned ENTRIES = 3,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [ENTRIES-1:0][7:0]     bytes_i,
  output logic                        we_o,
  output logic [IDX_W-1:0]            idx_o,
  output logic [DATA_W-1:0]           data_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0][7:0] bytes_q;
  logic                    we_q;
  logic [IDX_W-1:0]        idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      idx_q   <= '0;
      bytes_q <= '0;
    end else if (start_i) begin
      we_q    <= 1'b1;
      idx_q   <= '0;
      bytes_q <= bytes_i;
    end else if (we_q) begin
      if (idx_q == LAST) begin
        we_q  <= 1'b0;
        idx_q <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  logic [7:0] sel_byte;
  always_comb begin
    sel_byte = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (idx_q == IDX_W'(i)) sel_byte = bytes_q[i];
    end
  end

  assign we_o   = we_q;
  assign idx_o  = idx_q;
  assign data_o = {{(DATA_W-8){1'b0}}, sel_byte};

  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> (idx_q <= LAST)); // R3
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_q && idx_q != LAST && !start_i) |=> (we_q && idx_q == $past(idx_q) + 1'b1)); // R3
  AST_FILL_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_q && idx_q == LAST && !start_i) |=> !we_q); // R3
endmodule

// File: rtl/boot_cmd_pgload.sv
module boot_cmd_pgload #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned PREG_W    = 16,
  parameter int unsigned BLK_W     = 12,
  parameter int unsigned PG_W      = 8,
  parameter int unsigned PAGE_STEP = 4,
  parameter logic [BLK_W-1:0] DENSITY_MASK = 12'h400,
  localparam int unsigned SEC_W    = BLK_W + PG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              clr_i,
  input  logic              pg_wr_i,
  input  logic [PREG_W-1:0] pg_data_i,
  input  logic [DATA_W-1:0] blk_i,
  input  logic              done_i,
  output logic              req_o,
  output logic [SEC_W-1:0]  sector_o,
  output logic [PREG_W-1:0] page_o
);
  logic [BLK_W-1:0]  blk_eff;
  logic [PREG_W-1:0] page_q;
  logic [SEC_W-1:0]  sector_q;
  logic              req_q;
  logic              issue;
  logic [PG_W-1:0]   page_next;

  generate
    if (DENSITY_MASK == '0) begin : g_no_density
      assign blk_eff = blk_i[BLK_W-1:0];
    end else begin : g_density
      assign blk_eff = blk_i[BLK_W-1:0] | (blk_i[DATA_W-1] ? DENSITY_MASK : '0);
    end
  endgenerate

  assign issue     = start_i && !req_q;
  assign page_next = page_q[PG_W-1:0] + PG_W'(PAGE_STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
    end else if (pg_wr_i) begin
      page_q <= pg_data_i;
    end else if (issue) begin
      page_q <= {{(PREG_W-PG_W){1'b0}}, page_next};
    end else if (clr_i) begin
      page_q <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q    <= 1'b0;
      sector_q <= '0;
    end else if (issue) begin
      req_q    <= 1'b1;
      sector_q <= {blk_eff, page_q[PG_W-1:0]};
    end else if (req_q && done_i) begin
      req_q    <= 1'b0;
    end
  end

  assign req_o    = req_q;
  assign sector_o = sector_q;
  assign page_o   = page_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !done_i) |=> (req_q && $stable(sector_q))); // R7
  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && done_i) |=> !req_q); // R7
  AST_BUSY_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && start_i && !pg_wr_i && !clr_i) |=> $stable(page_q)); // R8
  AST_PAGE_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && !pg_wr_i) |=> (page_q[PREG_W-1:PG_W] == '0)); // R6
  AST_PG_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_wr_i |=> (page_q == $past(pg_data_i))); // R10
endmodule

// File: rtl/boot_cmd_decoder.sv
module boot_cmd_decoder
  import boot_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PREG_W = 16,
  parameter int unsigned BLK_W  = 12,
  parameter int unsigned PG_W   = 8,
  parameter logic [BLK_W-1:0] DENSITY_MASK = 12'h400,
  localparam int unsigned SEC_W   = BLK_W + PG_W,
  localparam int unsigned ID_ENT  = 3,
  localparam int unsigned IDX_W   = $clog2(ID_ENT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              pg_wr_i,
  input  logic [PREG_W-1:0] pg_data_i,
  input  logic [DATA_W-1:0] blk_reg_i,
  input  logic [7:0]        mfr_id_i,
  input  logic [7:0]        dev_id_i,
  input  logic [DATA_W-1:0] wp_status_i,
  input  logic              load_done_i,
  output logic              rst_req_o,
  output logic              unk_cmd_o,
  output logic              buf_we_o,
  output logic [IDX_W-1:0]  buf_idx_o,
  output logic [DATA_W-1:0] buf_data_o,
  output logic              load_req_o,
  output logic [SEC_W-1:0]  load_sector_o,
  output logic [PREG_W-1:0] page_o
);
  logic        hit;
  cmd_strobe_t cmd;
  logic [ID_ENT-1:0][7:0] id_bytes;

  assign id_bytes = {wp_status_i[7:0], dev_id_i, mfr_id_i};

  boot_cmd_window #(.ADDR_W(ADDR_W)) u_window (
    .wr_en_i (wr_en_i),
    .addr_i  (wr_addr_i),
    .hit_o   (hit)
  );

  boot_cmd_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (hit),
    .data_i    (wr_data_i),
    .cmd_o     (cmd),
    .rst_req_o (rst_req_o),
    .unk_cmd_o (unk_cmd_o)
  );

  boot_cmd_idfill #(.DATA_W(DATA_W), .ENTRIES(ID_ENT)) u_idfill (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cmd.id),
    .bytes_i (id_bytes),
    .we_o    (buf_we_o),
    .idx_o   (buf_idx_o),
    .data_o  (buf_data_o)
  );

  boot_cmd_pgload #(
    .DATA_W(DATA_W), .PREG_W(PREG_W), .BLK_W(BLK_W), .PG_W(PG_W),
    .PAGE_STEP(4), .DENSITY_MASK(DENSITY_MASK)
  ) u_pgload (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (cmd.load),
    .clr_i     (cmd.rst),
    .pg_wr_i   (pg_wr_i),
    .pg_data_i (pg_data_i),
    .blk_i     (blk_reg_i),
    .done_i    (load_done_i),
    .req_o     (load_req_o),
    .sector_o  (load_sector_o),
    .page_o    (page_o)
  );

  AST_OUTSIDE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !hit) |=> (!rst_req_o && !unk_cmd_o)); // R1
  AST_RESET_CLEARS_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o && !$past(pg_wr_i)) |-> (page_o == '0)); // R2
endmodule

// File: tb/boot_cmd_decoder_test.sv
`timescale 1ns/100ps
module boot_cmd_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        wr_en = 0;
  logic [15:0] wr_addr = 0, wr_data = 0;
  logic        pg_wr = 0;
  logic [15:0] pg_data = 0, blk_reg = 0, wp_status = 0;
  logic [7:0]  mfr_id = 0, dev_id = 0;
  logic        load_done = 0;
  logic        rst_req, unk_cmd, buf_we, load_req;
  logic [1:0]  buf_idx;
  logic [15:0] buf_data, page;
  logic [19:0] load_sector;

  int checks = 0, failures = 0;

  boot_cmd_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pg_wr_i(pg_wr), .pg_data_i(pg_data),
    .blk_reg_i(blk_reg), .mfr_id_i(mfr_id), .dev_id_i(dev_id),
    .wp_status_i(wp_status), .load_done_i(load_done),
    .rst_req_o(rst_req), .unk_cmd_o(unk_cmd), .buf_we_o(buf_we),
    .buf_idx_o(buf_idx), .buf_data_o(buf_data), .load_req_o(load_req),
    .load_sector_o(load_sector), .page_o(page)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pgw(input logic [15:0] v);
    @(negedge clk); pg_wr = 1; pg_data = v;
    @(negedge clk); pg_wr = 0;
  endtask

  task automatic finish_load();
    @(negedge clk); load_done = 1;
    @(negedge clk); load_done = 0;
    chk("R7 req drops after done", load_req, 0);
  endtask

  task automatic t_reset_state();
    chk("R11 rst_req", rst_req, 0);
    chk("R11 unk", unk_cmd, 0);
    chk("R11 buf_we", buf_we, 0);
    chk("R11 load_req", load_req, 0);
    chk("R11 page", page, 0);
  endtask

  task automatic t_reset_cmd();
    pgw(16'h0038);
    chk("R10 page written", page, 16'h0038);
    bwrite(16'h0005, 16'h00F0);
    chk("R2 rst pulse", rst_req, 1);
    chk("R2 page cleared", page, 0);
    @(negedge clk);
    chk("R2 pulse one cycle", rst_req, 0);
  endtask

  task automatic t_window();
    bwrite(16'h0200, 16'h00F0);
    chk("R1 above low window no reset", rst_req, 0);
    bwrite(16'h7FFF, 16'h1234);
    chk("R1 gap no unknown", unk_cmd, 0);
    bwrite(16'h800F, 16'h00F0);
    chk("R1 high window decoded", rst_req, 1);
    blk_reg = 16'h0001; pgw(16'h0000);
    bwrite(16'h8000, 16'h00E0);
    bwrite(16'h8010, 16'h0000);
    chk("R1 outside write no load", load_req, 0);
    bwrite(16'h01FF, 16'h0000);
    chk("R1 still armed, load starts", load_req, 1);
    chk("R5 sector", load_sector, 20'h00100);
    finish_load();
  endtask

  task automatic t_id();
    mfr_id = 8'hEC; dev_id = 8'h48; wp_status = 16'hAB12;
    bwrite(16'h0000, 16'h0090);
    mfr_id = 8'h11; dev_id = 8'h22; wp_status = 16'h3333;
    chk("R3 we0", buf_we, 1); chk("R3 idx0", buf_idx, 0); chk("R3 mfr", buf_data, 16'h00EC);
    @(negedge clk);
    chk("R3 we1", buf_we, 1); chk("R3 idx1", buf_idx, 1); chk("R3 dev", buf_data, 16'h0048);
    @(negedge clk);
    chk("R3 we2", buf_we, 1); chk("R3 idx2", buf_idx, 2); chk("R3 wp low", buf_data, 16'h0012);
    @(negedge clk);
    chk("R3 fill ends", buf_we, 0);
  endtask

  task automatic t_load();
    blk_reg = 16'h0123; pgw(16'h0016);
    bwrite(16'h0040, 16'h00E0);
    chk("R4 arm no load yet", load_req, 0);
    bwrite(16'h0041, 16'h0000);
    chk("R7 req rises", load_req, 1);
    chk("R5 sector", load_sector, 20'h12316);
    chk("R6 page +4", page, 16'h001A);
    @(negedge clk); @(negedge clk);
    chk("R7 req held", load_req, 1);
    chk("R7 sector stable", load_sector, 20'h12316);
    finish_load();
  endtask

  task automatic t_density_wrap();
    blk_reg = 16'h8005; pgw(16'hAAFD);
    bwrite(16'h0000, 16'h00E0);
    bwrite(16'h0000, 16'h0000);
    chk("R5 density sector", load_sector, 20'h405FD);
    chk("R6 page wraps", page, 16'h0001);
    finish_load();
  endtask

  task automatic t_cancel();
    pgw(16'h0020);
    bwrite(16'h0010, 16'h00E0);
    bwrite(16'h0010, 16'h0001);
    chk("R4 nonzero no load", load_req, 0);
    chk("R4 nonzero no unknown", unk_cmd, 0);
    bwrite(16'h0010, 16'h00E0);
    bwrite(16'h0010, 16'h00F0);
    chk("R4 reset code as second cycle ignored", rst_req, 0);
    chk("R4 page kept", page, 16'h0020);
    bwrite(16'h0010, 16'h0000);
    chk("R4 disarmed: zero is unknown", unk_cmd, 1);
    chk("R4 disarmed: no load", load_req, 0);
  endtask

  task automatic t_busy();
    blk_reg = 16'h0002; pgw(16'h0008);
    bwrite(16'h0000, 16'h00E0);
    bwrite(16'h0000, 16'h0000);
    chk("R7 first load", load_sector, 20'h00208);
    bwrite(16'h0000, 16'h00E0);
    bwrite(16'h0000, 16'h0000);
    chk("R8 req still high", load_req, 1);
    chk("R8 sector unchanged", load_sector, 20'h00208);
    chk("R8 page unchanged", page, 16'h000C);
    finish_load();
    @(negedge clk);
    chk("R8 no second request", load_req, 0);
  endtask

  task automatic t_unknown();
    pgw(16'h0044);
    bwrite(16'h0100, 16'h1234);
    chk("R9 unknown pulse", unk_cmd, 1);
    chk("R9 no reset", rst_req, 0);
    chk("R9 no fill", buf_we, 0);
    chk("R9 no load", load_req, 0);
    chk("R9 page kept", page, 16'h0044);
    @(negedge clk);
    chk("R9 pulse one cycle", unk_cmd, 0);
  endtask

  task automatic t_pg_priority();
    blk_reg = 16'h0003; pgw(16'h0010);
    bwrite(16'h0000, 16'h00E0);
    @(negedge clk); wr_en = 1; wr_addr = 0; wr_data = 0; pg_wr = 1; pg_data = 16'h0077;
    @(negedge clk); wr_en = 0; pg_wr = 0;
    chk("R10 load uses old page", load_sector, 20'h00310);
    chk("R10 page write wins", page, 16'h0077);
    finish_load();
  endtask

  logic done_flag = 0;
  initial begin
    #(5ns * 20000);
    if (!done_flag) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_reset_cmd();
    t_window();
    t_id();
    t_load();
    t_density_wrap();
    t_cancel();
    t_busy();
    t_unknown();
    t_pg_priority();
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule